// File: doc/BRIEF.md
# Count-Down Event Timer

A single-channel timer peripheral sitting on a plain register bus: an address, write data, separate write and read strobes, and combinational read data. Software programs one load value split across two bus-width words, then turns the timer on in one of two modes. In periodic mode the counter reloads itself on every expiry and keeps running. In single-shot mode it fires once and then waits to be re-armed.

Every expiry sets a sticky status bit. Software clears it by writing a one to it. A mask bit in the control word decides whether that status reaches the level interrupt output. The intended driver flow is always the same three steps: stop the timer, write both load halves, then start it again. The counter picks up the load value only when the enable bit goes from 0 to 1.

The counter is twice the bus width. With a 32-bit bus this gives a 64-bit count.

Top module: `evt_timer`

## Requirements
- R1: After reset every mapped register reads 0, the counter is stopped and `irq_o` is low.
- R2: The low half of the load value is at byte offset 0x00 and the high half is at 0x04. Both read back what was written. Together they form one load value of twice the bus width, with the high half as the upper bits.
- R3: The control word is at offset 0x10. Bit 0 is enable, bit 1 is mode (0 periodic, 1 single-shot) and bit 2 is interrupt unmask. It reads back those three bits, with zeros above them. The status word is at offset 0x18, with the pending flag in bit 0.
- R4: A control write that takes enable from 0 to 1 copies the load value N into the counter. The first expiry then happens on the (N+1)-th clock edge after the write edge.
- R5: In periodic mode the counter reloads N at each expiry, so expiries repeat every N+1 clocks.
- R6: In single-shot mode exactly one expiry occurs. No further expiry occurs until enable is cleared and set again.
- R7: Each expiry sets the status flag, which stays set. Writing 1 to status bit 0 clears it. Writing 0 to that bit has no effect.
- R8: If an expiry and a status clear fall on the same edge, the flag stays set.
- R9: `irq_o` is high exactly when the status flag is set and the unmask bit is 1. With unmask at 0 the flag still sets, but `irq_o` stays low.
- R10: Writing 0 to the control word stops the counter. From the edge after that write, no expiry occurs.
- R11: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R12: A control write made while enable is already 1 does not reload the counter, and the pending expiry keeps its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe; read data is 0 when low |
| rdata_o | output | DATA_W | Read data, combinational from address |
| irq_o | output | 1 | Level interrupt: pending flag and unmask |

## Verification
The bench builds the timer with an 8-bit data bus, which makes the counter 16 bits wide. This brings the high load half within reach of a short run: loading 0x100 has to produce its first expiry after 257 clocks, which shows how the two halves combine. Directed sequences cover the following:
- each requirement with a cycle-exact count of expiry spacing;
- a clear that lands on an expiry edge;
- a control rewrite in mid-count.

Seeded random bus traffic is then compared each cycle against a reference model written from the requirements.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned LOAD_OFS    = 'h00;
  localparam int unsigned WORD_STRIDE = 4;
  localparam int unsigned CTRL_OFS    = 'h10;
  localparam int unsigned STAT_OFS    = 'h18;
  localparam int unsigned CTRL_W      = 3;
  localparam int unsigned NUM_HALVES  = 2;

  // field order is the bit order of the control word: [2] unmask, [1] mode, [0] enable
  typedef struct packed {
    logic unmask;
    logic oneshot;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           wr_i,
  input  logic                           rd_i,
  output logic [DATA_W-1:0]              rdata_o,
  input  logic                           expire_i,
  output logic [NUM_HALVES*DATA_W-1:0]   load_o,
  output ctrl_t                          ctrl_o,
  output logic                           start_o,
  output logic                           stat_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  ctrl_t ctrl_q;
  logic  stat_q;
  logic  hit_ctrl, hit_stat;

  assign hit_ctrl = (addr_i == CTRL_A);
  assign hit_stat = (addr_i == STAT_A);

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] HALF_A = ADDR_W'(LOAD_OFS + h * WORD_STRIDE);
    logic [DATA_W-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         half_q <= '0;
      else if (wr_i && addr_i == HALF_A)   half_q <= wdata_i;
    end
    assign load_o[h*DATA_W +: DATA_W] = half_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ctrl_q <= '0;
    else if (wr_i && hit_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  // expiry beats a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              stat_q <= 1'b0;
    else if (expire_i)                        stat_q <= 1'b1;
    else if (wr_i && hit_stat && wdata_i[0])  stat_q <= 1'b0;
  end

  assign start_o = wr_i && hit_ctrl && wdata_i[0] && !ctrl_q.en;

  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int unsigned h = 0; h < NUM_HALVES; h++) begin
      if (addr_i == ADDR_W'(LOAD_OFS + h * WORD_STRIDE)) rd_val = load_o[h*DATA_W +: DATA_W];
    end
    if (hit_ctrl) rd_val[CTRL_W-1:0] = ctrl_q;
    if (hit_stat) rd_val[0] = stat_q;
  end

  assign rdata_o = rd_i ? rd_val : '0;
  assign ctrl_o  = ctrl_q;
  assign stat_o  = stat_q;
endmodule

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             oneshot_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign expire_o = en_i && armed_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= load_i;
      armed_q <= 1'b1;
    end else if (!en_i) begin
      armed_q <= 1'b0;
    end else if (expire_o) begin
      if (oneshot_i) armed_q <= 1'b0;
      else           cnt_q   <= load_i;
    end else if (armed_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = NUM_HALVES * DATA_W;

  logic [CNT_W-1:0] load;
  logic [CNT_W-1:0] cnt;
  ctrl_t            ctrl_q;
  logic             stat_q;
  logic             start;
  logic             expire;

  evt_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .rdata_o  (rdata_o),
    .expire_i (expire),
    .load_o   (load),
    .ctrl_o   (ctrl_q),
    .start_o  (start),
    .stat_o   (stat_q)
  );

  evt_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctrl_q.en),
    .oneshot_i (ctrl_q.oneshot),
    .start_i   (start),
    .load_i    (load),
    .expire_o  (expire),
    .cnt_o     (cnt)
  );

  assign irq_o = stat_q && ctrl_q.unmask;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       wbit0,
  input logic                       irq_o,
  input logic                       expire,
  input logic                       stat,
  input logic                       en,
  input logic                       oneshot,
  input logic                       unmask,
  input logic [2*DATA_W-1:0]        cnt,
  input logic [2*DATA_W-1:0]        load
);
  logic a_ctrl, a_stat, a_mapped;
  assign a_ctrl   = (addr_i == ADDR_W'(CTRL_OFS));
  assign a_stat   = (addr_i == ADDR_W'(STAT_OFS));
  assign a_mapped = a_ctrl || a_stat || (addr_i == ADDR_W'(LOAD_OFS))
                    || (addr_i == ADDR_W'(LOAD_OFS + WORD_STRIDE));

  // R4
  start_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && a_ctrl && wbit0 && !en) |=> (cnt == $past(load)));
  // R5
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !oneshot) |=> (cnt == $past(load)));
  // R6
  single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && oneshot) |=> !expire);
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && a_stat && wbit0 && !expire) |=> !stat);
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> stat);
  // R9
  masked_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat && !unmask) |-> !irq_o);
  // R9
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> stat);
  // R10
  stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !expire);
  // R11
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !a_mapped) |=> ($stable(load) && $stable(en) && $stable(oneshot) && $stable(unmask)));
endmodule

bind evt_timer evt_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wbit0   (wdata_i[0]),
  .irq_o   (irq_o),
  .expire  (expire),
  .stat    (stat_q),
  .en      (ctrl_q.en),
  .oneshot (ctrl_q.oneshot),
  .unmask  (ctrl_q.unmask),
  .cnt     (cnt),
  .load    (load)
);

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_LO = 5'h00, A_HI = 5'h04, A_CTRL = 5'h10, A_STAT = 5'h18;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          wr_i = 1'b0, rd_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic          irq_o;

  int n_chk = 0, n_bad = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  evt_timer #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model from the requirements
  logic [DW-1:0]   m_lo, m_hi;
  logic [2:0]      m_ctrl;
  logic            m_stat, m_arm;
  logic [2*DW-1:0] m_cnt;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lo <= '0; m_hi <= '0; m_ctrl <= '0; m_stat <= 1'b0; m_arm <= 1'b0; m_cnt <= '0;
    end else begin
      automatic logic fire = m_ctrl[0] && m_arm && (m_cnt == 0);
      if (wr_i && addr_i == A_CTRL && wdata_i[0] && !m_ctrl[0]) begin
        m_cnt <= {m_hi, m_lo}; m_arm <= 1'b1;
      end else if (!m_ctrl[0]) m_arm <= 1'b0;
      else if (fire) begin
        if (m_ctrl[1]) m_arm <= 1'b0; else m_cnt <= {m_hi, m_lo};
      end else if (m_arm) m_cnt <= m_cnt - 1'b1;
      if (wr_i && addr_i == A_LO)   m_lo <= wdata_i;
      if (wr_i && addr_i == A_HI)   m_hi <= wdata_i;
      if (wr_i && addr_i == A_CTRL) m_ctrl <= wdata_i[2:0];
      if (fire) m_stat <= 1'b1;
      else if (wr_i && addr_i == A_STAT && wdata_i[0]) m_stat <= 1'b0;
    end
  end

  function automatic logic [DW-1:0] m_read(logic [AW-1:0] a);
    case (a)
      A_LO:   return m_lo;
      A_HI:   return m_hi;
      A_CTRL: return DW'(m_ctrl);
      A_STAT: return DW'(m_stat);
      default: return '0;
    endcase
  endfunction

  // R9: interrupt level against model every cycle
  always @(negedge clk_i) if (rst_ni && mon_en) check("R9 irq level", irq_o, m_stat && m_ctrl[2]);

  // tasks start and end at a negedge
  task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    logic [DW-1:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wait_irq(int max, output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!irq_o && n < max);
  endtask

  task automatic stop_clear();
    bus_wr(A_CTRL, 8'h00);
    bus_wr(A_STAT, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    mon_en = 1'b1;

    // R1 reset state
    check("R1 irq", irq_o, 0);
    rd_chk("R1 lo", A_LO, 0);
    rd_chk("R1 hi", A_HI, 0);
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 stat", A_STAT, 0);

    // R2 halves readback
    bus_wr(A_LO, 8'h5A); bus_wr(A_HI, 8'hC3);
    rd_chk("R2 lo", A_LO, 8'h5A);
    rd_chk("R2 hi", A_HI, 8'hC3);

    // R3 control field readback, upper bits zero
    bus_wr(A_CTRL, 8'hFA);
    rd_chk("R3 ctrl fa", A_CTRL, 8'h02);
    bus_wr(A_CTRL, 8'h06);
    rd_chk("R3 ctrl 06", A_CTRL, 8'h06);
    bus_wr(A_CTRL, 8'h00);

    // R11 unmapped offsets
    bus_wr(A_LO, 8'hA5); bus_wr(A_HI, 8'h3C);
    bus_wr(5'h08, 8'hFF); bus_wr(5'h0C, 8'hFF); bus_wr(5'h14, 8'hFF); bus_wr(5'h1C, 8'hFF);
    rd_chk("R11 rd 08", 5'h08, 0);
    rd_chk("R11 rd 14", 5'h14, 0);
    rd_chk("R11 rd 1c", 5'h1C, 0);
    rd_chk("R11 lo kept", A_LO, 8'hA5);
    rd_chk("R11 hi kept", A_HI, 8'h3C);
    rd_chk("R11 ctrl kept", A_CTRL, 0);

    // R4 / R5 periodic, N=5
    bus_wr(A_LO, 5); bus_wr(A_HI, 0); bus_wr(A_CTRL, 8'h05);
    wait_irq(50, n);
    check("R4 first expiry", n, 6);
    repeat (2) begin
      bus_wr(A_STAT, 1);  // clear lands one edge after expiry
      wait_irq(50, n);
      check("R5 period", n, 5);
    end
    stop_clear();

    // R2 high half feeds the upper count bits: N=0x100
    bus_wr(A_LO, 0); bus_wr(A_HI, 1); bus_wr(A_CTRL, 8'h05);
    wait_irq(400, n);
    check("R2 wide load", n, 257);
    stop_clear();

    // R6 single-shot, N=3
    bus_wr(A_LO, 3); bus_wr(A_HI, 0); bus_wr(A_CTRL, 8'h07);
    wait_irq(50, n);
    check("R6 fire", n, 4);
    bus_wr(A_STAT, 1);
    wait_irq(40, n);
    check("R6 no refire irq", irq_o, 0);
    rd_chk("R6 no refire stat", A_STAT, 0);
    bus_wr(A_CTRL, 0); bus_wr(A_CTRL, 8'h07);
    wait_irq(50, n);
    check("R6 rearm", n, 4);
    stop_clear();

    // R9 masked status
    bus_wr(A_LO, 2); bus_wr(A_CTRL, 8'h01);
    repeat (5) @(negedge clk_i);
    check("R9 masked irq", irq_o, 0);
    rd_chk("R9 masked stat", A_STAT, 1);
    bus_wr(A_CTRL, 8'h05);
    check("R9 unmask", irq_o, 1);
    stop_clear();

    // R12 control rewrite mid-count, N=5
    bus_wr(A_LO, 5); bus_wr(A_CTRL, 8'h05);
    repeat (2) @(negedge clk_i);
    check("R12 before", irq_o, 0);
    bus_wr(A_CTRL, 8'h05);
    wait_irq(50, n);
    check("R12 no reload", n, 3);

    // R7 clear semantics with timer stopped
    bus_wr(A_CTRL, 0);
    rd_chk("R7 sticky", A_STAT, 1);
    bus_wr(A_STAT, 0);
    rd_chk("R7 write0", A_STAT, 1);
    bus_wr(A_STAT, 8'hFE);
    rd_chk("R7 writeFE", A_STAT, 1);
    bus_wr(A_STAT, 1);
    rd_chk("R7 clear", A_STAT, 0);

    // R8 clear on expiry edge, N=3: expiries at E+4, E+8
    bus_wr(A_LO, 3); bus_wr(A_CTRL, 8'h05);
    wait_irq(50, n);
    check("R8 first", n, 4);
    repeat (3) @(negedge clk_i);
    bus_wr(A_STAT, 1);
    check("R8 set wins", irq_o, 1);
    bus_wr(A_STAT, 1);
    check("R7 clear off-edge", irq_o, 0);
    stop_clear();

    // R10 stop
    bus_wr(A_LO, 2); bus_wr(A_CTRL, 8'h05);
    repeat (4) @(negedge clk_i);
    stop_clear();
    repeat (20) @(negedge clk_i);
    rd_chk("R10 stat", A_STAT, 0);
    rd_chk("R10 ctrl", A_CTRL, 0);

    // random traffic against model (R3 R4 R5 R6 R7 R11)
    for (int i = 0; i < 1500; i++) begin
      int unsigned op = $urandom % 8;
      case (op)
        0, 1: @(negedge clk_i);
        2: bus_wr(A_LO, DW'($urandom % 12));
        3: bus_wr(A_HI, ($urandom % 16 == 0) ? 8'h01 : 8'h00);
        4: bus_wr(A_CTRL, DW'($urandom));
        5: bus_wr(A_STAT, DW'($urandom));
        6: begin
          logic [AW-1:0] a = AW'($urandom);
          logic [DW-1:0] v;
          logic [DW-1:0] e = m_read(a);
          bus_rd(a, v);
          check("R11 random read", v, e);
        end
        default: bus_wr(5'h0C, DW'($urandom));
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule